// File: doc/BRIEF.md
# Shared Frequency Ramp Controller

This block owns one rate-limited stepper that is shared by two frequency channels, CPU and SRC. Each channel has a target N value written from outside and a current N value that the block drives toward it. The channel that owns the stepper moves its current value by one N step per rate tick, so an overclocking change becomes a slow glide rather than a jump. The other channel still follows its own target, but it takes the new value in a single step.

Ownership is either automatic or set by a register bit. In automatic mode the stepper goes to whichever channel last got a new target. If both targets change in the same cycle, the CPU channel wins. In manual mode a select bit names the owner. A busy flag is high while the owning channel has not yet reached its target. The rate tick comes from a free-running prescaler of the system clock, and `TICK_DIV` is chosen so that one N step per tick matches the allowed frequency slew.

Top module: `freq_ramp_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released until a target changes, both current values are 0 and busy is 0. Automatic mode is in effect, and the CPU channel owns the stepper.
- R2: The rate tick fires once every `TICK_DIV` clock cycles. The first tick falls on the `TICK_DIV`-th rising edge after reset is released. The owning channel's current value changes only on a tick edge, and by exactly 1.
- R3: The owning channel's current value moves monotonically toward the latched target. It stops exactly at that target and then holds it, with no overshoot.
- R4: A target value is latched at the first rising edge at which it is presented. A non-owning channel's current value equals that latched target after the next rising edge.
- R5: In automatic mode (`manual_mode_i` = 0), a channel whose target input differs from its latched target becomes the owner at that edge. It then ramps rather than jumps.
- R6: In automatic mode, if both target inputs change in the same cycle, the CPU channel becomes the owner and the SRC channel jumps to its new value.
- R7: In manual mode (`manual_mode_i` = 1), `manual_sel_i` names the owner (0 = CPU, 1 = SRC) from the next edge on, and target changes do not move ownership.
- R8: `busy_o` is 1 exactly when the owning channel's current value differs from its latched target.
- R9: If a target changes during a ramp, the ramp goes on from the present current value toward the new target, with no restart and no jump.
- R10: When ownership passes away from a channel in mid-ramp, that channel's current value jumps to its latched target on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_target_i | input | N_W | Target N value for the CPU channel |
| src_target_i | input | N_W | Target N value for the SRC channel |
| manual_mode_i | input | 1 | 0 = automatic ownership, 1 = ownership by `manual_sel_i` |
| manual_sel_i | input | 1 | Manual owner: 0 = CPU, 1 = SRC |
| cpu_current_o | output | N_W | Present N value of the CPU channel |
| src_current_o | output | N_W | Present N value of the SRC channel |
| busy_o | output | 1 | The owning channel has not reached its target |

## Verification
A target presented before rising edge k is latched, and ownership is decided, at edge k. `busy_o` therefore reflects the change in the cycle after edge k. A non-owning channel shows its new value after edge k+1, and an owning channel moves only on tick edges from k+1 onward.

The bench drives inputs and compares outputs only on falling edges. A cycle-level model, written from these rules, advances on each rising edge from the inputs that were set up before it, so every comparison falls half a cycle after the edge that made the result due. Directed checks wait an explicit number of falling edges that is counted from these latencies.

// File: rtl/freq_ramp_pkg.sv
package freq_ramp_pkg;

    localparam int NW_MAX = 16;

    typedef enum logic {
        CH_CPU = 1'b0,
        CH_SRC = 1'b1
    } chan_e;

    typedef struct packed {
        logic [NW_MAX-1:0] cpu;
        logic [NW_MAX-1:0] src;
    } pair_t;

    // One N step toward the goal, never past it.
    function automatic logic [NW_MAX-1:0] step_toward(
        input logic [NW_MAX-1:0] cur,
        input logic [NW_MAX-1:0] goal
    );
        if (cur < goal)      return cur + 1'b1;
        else if (cur > goal) return cur - 1'b1;
        else                 return cur;
    endfunction

    function automatic chan_e pick_owner(
        input logic  manual,
        input logic  sel,
        input logic  cpu_new,
        input logic  src_new,
        input chan_e prev
    );
        if (manual)       return chan_e'(sel);
        else if (cpu_new) return CH_CPU;
        else if (src_new) return CH_SRC;
        else              return prev;
    endfunction

endpackage

// File: rtl/ramp_tick.sv
module ramp_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ramp_arbiter.sv
module ramp_arbiter
    import freq_ramp_pkg::*;
#(
    parameter int N_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] cpu_target_i,
    input  logic [N_W-1:0] src_target_i,
    input  logic           manual_mode_i,
    input  logic           manual_sel_i,
    output logic [N_W-1:0] cpu_tgt_q,
    output logic [N_W-1:0] src_tgt_q,
    output chan_e          owner_q
);
    logic  cpu_new, src_new;
    chan_e owner_d;

    assign cpu_new = (cpu_target_i != cpu_tgt_q);
    assign src_new = (src_target_i != src_tgt_q);
    assign owner_d = pick_owner(manual_mode_i, manual_sel_i, cpu_new, src_new, owner_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_tgt_q <= '0;
            src_tgt_q <= '0;
            owner_q   <= CH_CPU;
        end else begin
            cpu_tgt_q <= cpu_target_i;
            src_tgt_q <= src_target_i;
            owner_q   <= owner_d;
        end
    end
endmodule

// File: rtl/ramp_channel.sv
module ramp_channel
    import freq_ramp_pkg::*;
#(
    parameter int    N_W = 9,
    parameter chan_e ME  = CH_CPU
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_i,
    input  chan_e          owner_i,
    input  logic [N_W-1:0] tgt_i,
    output logic [N_W-1:0] cur_q
);
    logic           owned;
    logic [N_W-1:0] stepped;

    assign owned   = (owner_i == ME);
    assign stepped = N_W'(step_toward(NW_MAX'(cur_q), NW_MAX'(tgt_i)));

    always_ff @(posedge clk) begin
        if (rst)         cur_q <= '0;
        else if (!owned) cur_q <= tgt_i;
        else if (tick_i) cur_q <= stepped;
    end
endmodule

// File: rtl/freq_ramp_ctrl.sv
module freq_ramp_ctrl
    import freq_ramp_pkg::*;
#(
    parameter int N_W      = 9,
    parameter int TICK_DIV = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] cpu_target_i,
    input  logic [N_W-1:0] src_target_i,
    input  logic           manual_mode_i,
    input  logic           manual_sel_i,
    output logic [N_W-1:0] cpu_current_o,
    output logic [N_W-1:0] src_current_o,
    output logic           busy_o
);
    localparam int NCH = 2;

    logic           tick_w;
    chan_e          owner_w;
    logic [N_W-1:0] cpu_tgt_w, src_tgt_w;
    logic [N_W-1:0] tgt_w [NCH];
    logic [N_W-1:0] cur_w [NCH];

    ramp_tick #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst(rst), .tick_o(tick_w)
    );

    ramp_arbiter #(.N_W(N_W)) arb_i (
        .clk(clk), .rst(rst),
        .cpu_target_i(cpu_target_i), .src_target_i(src_target_i),
        .manual_mode_i(manual_mode_i), .manual_sel_i(manual_sel_i),
        .cpu_tgt_q(cpu_tgt_w), .src_tgt_q(src_tgt_w), .owner_q(owner_w)
    );

    assign tgt_w[0] = cpu_tgt_w;
    assign tgt_w[1] = src_tgt_w;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        ramp_channel #(.N_W(N_W), .ME(chan_e'(ch))) chan_i (
            .clk(clk), .rst(rst), .tick_i(tick_w), .owner_i(owner_w),
            .tgt_i(tgt_w[ch]), .cur_q(cur_w[ch])
        );
    end

    assign cpu_current_o = cur_w[0];
    assign src_current_o = cur_w[1];
    assign busy_o = (owner_w == CH_SRC) ? (cur_w[1] != src_tgt_w)
                                        : (cur_w[0] != cpu_tgt_w);
endmodule

// File: rtl/freq_ramp_ctrl_chk.sv
module freq_ramp_ctrl_chk
    import freq_ramp_pkg::*;
#(
    parameter int N_W = 9
) (
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input chan_e          owner,
    input logic [N_W-1:0] cpu_tgt,
    input logic [N_W-1:0] src_tgt,
    input logic [N_W-1:0] cpu_target_i,
    input logic [N_W-1:0] src_target_i,
    input logic           manual_mode_i,
    input logic           manual_sel_i,
    input logic [N_W-1:0] cpu_current_o,
    input logic [N_W-1:0] src_current_o
);
    // R2: no tick, the owned CPU value holds
    assert_cpu_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && owner == CH_CPU) |=> $stable(cpu_current_o));

    // R2: no tick, the owned SRC value holds
    assert_src_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && owner == CH_SRC) |=> $stable(src_current_o));

    // R3: a value at its latched target stays put
    assert_no_overshoot_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_current_o == cpu_tgt) |=> $stable(cpu_current_o));

    // R4: non-owner follows the latched target
    assert_src_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (owner != CH_SRC) |=> (src_current_o == $past(src_tgt)));

    // R6: simultaneous new targets in auto mode give the CPU the stepper
    assert_cpu_priority_R6: assert property (@(posedge clk) disable iff (rst)
        (!manual_mode_i && cpu_target_i != cpu_tgt && src_target_i != src_tgt)
        |=> (owner == CH_CPU));

    // R7: manual select names the owner
    assert_manual_owner_R7: assert property (@(posedge clk) disable iff (rst)
        manual_mode_i |=> (owner == chan_e'($past(manual_sel_i))));
endmodule

bind freq_ramp_ctrl freq_ramp_ctrl_chk #(.N_W(N_W)) chk_i (
    .clk(clk), .rst(rst), .tick(tick_w), .owner(owner_w),
    .cpu_tgt(cpu_tgt_w), .src_tgt(src_tgt_w),
    .cpu_target_i(cpu_target_i), .src_target_i(src_target_i),
    .manual_mode_i(manual_mode_i), .manual_sel_i(manual_sel_i),
    .cpu_current_o(cpu_current_o), .src_current_o(src_current_o)
);

// File: tb/freq_ramp_ctrl_tb_top.sv
module freq_ramp_ctrl_tb_top;
    localparam int N_W = 9;
    localparam int DIV = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N_W-1:0] cpu_t = '0, src_t = '0;
    logic           man = 1'b0, sel = 1'b0;
    logic [N_W-1:0] cpu_c, src_c;
    logic           busy;

    int checks = 0, fails = 0, cyc = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0, m_tc = 0, m_ts = 0, m_own = 0, m_cc = 0, m_cs = 0;

    always #4 clk = ~clk;

    freq_ramp_ctrl #(.N_W(N_W), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .cpu_target_i(cpu_t), .src_target_i(src_t),
        .manual_mode_i(man), .manual_sel_i(sel),
        .cpu_current_o(cpu_c), .src_current_o(src_c), .busy_o(busy)
    );

    function automatic int step_m(int cur, int goal);
        if (cur < goal) return cur + 1;
        if (cur > goal) return cur - 1;
        return cur;
    endfunction

    function automatic int busy_m();
        return (m_own == 1) ? int'(m_cs != m_ts) : int'(m_cc != m_tc);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_tc = 0; m_ts = 0; m_own = 0; m_cc = 0; m_cs = 0;
        end else begin
            automatic int tk = (m_cnt == DIV - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            m_cc = (m_own == 0) ? (tk ? step_m(m_cc, m_tc) : m_cc) : m_tc;
            m_cs = (m_own == 1) ? (tk ? step_m(m_cs, m_ts) : m_cs) : m_ts;
            if (man)                  m_own = int'(sel);
            else if (int'(cpu_t) != m_tc) m_own = 0;
            else if (int'(src_t) != m_ts) m_own = 1;
            m_tc = int'(cpu_t);
            m_ts = int'(src_t);
        end
        if (cyc >= 190000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "cpu_current", int'(cpu_c), m_cc);
            check(cur_req, "src_current", int'(src_c), m_cs);
            check("R8", "busy", int'(busy), busy_m());
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        wait_n(3);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "cpu in reset", int'(cpu_c), 0);
        rst = 1'b0;
        wait_n(3);
        check("R1", "cpu after reset", int'(cpu_c), 0);
        check("R1", "src after reset", int'(src_c), 0);
        check("R1", "busy after reset", int'(busy), 0);

        // R2 R3: auto ramp 0 -> 5 on CPU
        cur_req = "R2";
        cpu_t = 9'd5;
        wait_n(2);
        check("R8", "busy during ramp", int'(busy), 1);
        check("R2", "cpu at most one step", int'(cpu_c <= 9'd1), 1);
        wait_n(5 * DIV + 4);
        check("R3", "cpu landed", int'(cpu_c), 5);
        check("R3", "busy cleared", int'(busy), 0);

        // R7 R4: manual CPU owner, SRC jumps
        cur_req = "R7";
        man = 1'b1; sel = 1'b0;
        wait_n(1);
        src_t = 9'd9;
        wait_n(2);
        check("R4", "src jumped", int'(src_c), 9);
        check("R7", "busy stays low", int'(busy), 0);
        man = 1'b0;
        wait_n(2);

        // R6: both change at once in auto mode
        cur_req = "R6";
        cpu_t = 9'd20; src_t = 9'd30;
        wait_n(2);
        check("R6", "src jumped", int'(src_c), 30);
        check("R6", "cpu still ramping", int'(cpu_c <= 9'd6), 1);
        check("R6", "busy on cpu ramp", int'(busy), 1);

        // R5 R10: SRC gets the stepper, CPU mid-ramp jumps
        cur_req = "R10";
        src_t = 9'd31;
        wait_n(2);
        check("R10", "cpu jumped", int'(cpu_c), 20);
        check("R5", "src ramps not jumps", int'(src_c), 30);
        check("R5", "busy on src ramp", int'(busy), 1);
        wait_n(DIV + 2);
        check("R5", "src arrived", int'(src_c), 31);

        // R9: retarget during ramp
        cur_req = "R9";
        cpu_t = 9'd40;
        wait_n(10 * DIV);
        check("R9", "cpu moved up", int'(cpu_c > 9'd25), 1);
        cpu_t = 9'd10;
        wait_n(2);
        check("R9", "no jump on retarget", int'(cpu_c > 9'd25), 1);
        wait_n(40 * DIV);
        check("R9", "cpu at new target", int'(cpu_c), 10);

        // random phase
        cur_req = "R2";
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom_range(15) == 0) cpu_t = N_W'($urandom_range(63));
            if ($urandom_range(15) == 0) src_t = N_W'($urandom_range(63));
            if ($urandom_range(63) == 0) man = ~man;
            if ($urandom_range(31) == 0) sel = ~sel;
            if (i == 3000) cur_req = "R3";
        end
        wait_n(4);
        summary();
    end
endmodule